// File: doc/BRIEF.md
# Conversion Cycle Timing Sequencer

This block runs in the conversion-clock domain of a self-calibrating successive-approximation converter and decides when the converter is busy. A command from the serial side (convert, self-calibrate, auto-zero, power down or power up) is armed by the serial port. The serial port then raises its transfer-ready flag, and the sequencer resynchronizes that flag and starts the command two conversion clocks later. Every interval is counted in conversion clocks. The analog side is modelled only by how long it takes. A conversion opens a sample window of selectable length, then a fixed-length conversion window, and ends with a one-cycle result strobe.

One active-low busy line reports every operation. It goes low when an operation starts and returns high when the operation ends, and that rising edge is the end-of-operation event. A hardware power-down pin takes priority over everything else. Releasing the pin, or issuing the software power-up command, starts a long power-up wait. An abort input from the serial port throws away a conversion in progress and starts a fresh sample window.

Top module: `conv_seq_top`

## Requirements
- R1: After reset `busy_n` is high and `sample_en`, `conv_act` and `res_vld` are low. `busy_n` is high only while no operation runs. `res_vld` is only ever high in the cycle in which `busy_n` has just returned high.
- R2: A rising edge on `xfer_rdy` launches the command on `cmd_op`. `busy_n` falls at the third clock edge that samples `xfer_rdy` high, counting the first such edge. Command codes: 1 convert, 2 self-calibrate, 3 auto-zero, 4 power down, 5 power up.
- R3: In a conversion, `sample_en` stays high for 6, 10, 18 or 34 cycles when `acq_code` is 0, 1, 2 or 3. The code is captured when the command launches.
- R4: After the sample window, `conv_act` stays high for exactly 44 cycles. `busy_n` is low for the sample length plus 44 cycles. `res_vld` pulses for one cycle as `busy_n` rises.
- R5: Self-calibration holds `busy_n` low for exactly 4944 cycles and gives no `res_vld`.
- R6: Auto-zero holds `busy_n` low for exactly 76 cycles and gives no `res_vld`.
- R7: While `pd_pin` is high, `busy_n` is low. A conversion in progress is terminated: `conv_act` is low by the third clock edge that samples the pin high, and no `res_vld` follows.
- R8: After `pd_pin` falls, `busy_n` rises at the 3503rd clock edge that samples the pin low, counting the first such edge. That is two synchronizer edges plus a 3500-cycle power-up wait (the default).
- R9: Command 4 keeps `busy_n` low indefinitely. Only command 5 ends it, and command 5 uses the same timing as R8, counted from the rise of `xfer_rdy`.
- R10: A one-cycle pulse on `abort` during a conversion restarts the sample window at the edge that samples the pulse. Busy time then continues for a full sample window plus 44 cycles. The aborted conversion produces no `res_vld`.
- R11: The following launches leave all outputs unchanged: codes 0, 6 and 7; code 5 while idle; any code other than 5 while powered down; and any launch while an operation runs. None of them queues a later start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_rdy | input | 1 | Transfer-ready flag from the serial domain; its rise launches a command |
| cmd_op | input | 3 | Command code, stable while `xfer_rdy` rises |
| acq_code | input | 2 | Sample-window length select |
| abort | input | 1 | Restart request for a conversion, synchronous to `clk` |
| pd_pin | input | 1 | Hardware power-down, active high, asynchronous |
| busy_n | output | 1 | Active-low busy; its rising edge marks the end of an operation |
| sample_en | output | 1 | High during the sample window |
| conv_act | output | 1 | High during the conversion window |
| res_vld | output | 1 | One-cycle strobe when a conversion result is complete |

## Verification
A wrong state or a corrupted counter shows up as a wrong busy low time, or as a busy line that never rises. Because every operation is bounded, either error appears within one operation length of its cause. That is at most 4944 cycles for calibration and 3500 for power-up. A lost abort or a lost power-down shows up as a stray `res_vld`, or as `conv_act` still high a few cycles after the request. A launch that is accepted when it should be ignored pulls `busy_n` low within three edges.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_CONV,
        ST_CAL,
        ST_AZ,
        ST_PDN,
        ST_PUP
    } seq_state_e;

    localparam logic [2:0] OP_CONV = 3'd1;
    localparam logic [2:0] OP_CAL  = 3'd2;
    localparam logic [2:0] OP_AZ   = 3'd3;
    localparam logic [2:0] OP_PDN  = 3'd4;
    localparam logic [2:0] OP_PUP  = 3'd5;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/seq_acq_len.sv
module seq_acq_len #(
    parameter int CNT_W = 13,
    parameter int ACQ0  = 6,
    parameter int ACQ1  = 10,
    parameter int ACQ2  = 18,
    parameter int ACQ3  = 34
) (
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] len
);
    always_comb begin
        unique case (code)
            2'd0:    len = CNT_W'(ACQ0);
            2'd1:    len = CNT_W'(ACQ1);
            2'd2:    len = CNT_W'(ACQ2);
            default: len = CNT_W'(ACQ3);
        endcase
    end
endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
#(
    parameter int CNT_W    = 13,
    parameter int CONV_LEN = 44,
    parameter int CAL_LEN  = 4944,
    parameter int AZ_LEN   = 76,
    parameter int PUP_LEN  = 3500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rdy_s,
    input  logic             pd_s,
    input  logic [2:0]       op,
    input  logic [1:0]       acq_code,
    input  logic             abort,
    input  logic [CNT_W-1:0] launch_len,
    input  logic [CNT_W-1:0] restart_len,
    output logic [1:0]       acq_held,
    output logic             busy_n,
    output logic             sample_en,
    output logic             conv_act,
    output logic             res_vld
);
    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       acq;
        logic             rdy;
        logic             pd;
        logic             vld;
    } core_st_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    core_st_t st_d, st_q;
    logic     launch;

    assign launch = rdy_s & ~st_q.rdy;

    always_comb begin
        st_d     = st_q;
        st_d.rdy = rdy_s;
        st_d.pd  = pd_s;
        st_d.vld = 1'b0;
        if (pd_s) begin
            st_d.state = ST_PDN;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.state)
                ST_IDLE: begin
                    if (launch) begin
                        unique case (op)
                            OP_CONV: begin
                                st_d.state = ST_ACQ;
                                st_d.cnt   = launch_len - ONE;
                                st_d.acq   = acq_code;
                            end
                            OP_CAL: begin
                                st_d.state = ST_CAL;
                                st_d.cnt   = CNT_W'(CAL_LEN - 1);
                            end
                            OP_AZ: begin
                                st_d.state = ST_AZ;
                                st_d.cnt   = CNT_W'(AZ_LEN - 1);
                            end
                            OP_PDN: begin
                                st_d.state = ST_PDN;
                                st_d.cnt   = '0;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ACQ: begin
                    if (abort) begin
                        st_d.cnt = restart_len - ONE;
                    end else if (st_q.cnt == '0) begin
                        st_d.state = ST_CONV;
                        st_d.cnt   = CNT_W'(CONV_LEN - 1);
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                ST_CONV: begin
                    if (abort) begin
                        st_d.state = ST_ACQ;
                        st_d.cnt   = restart_len - ONE;
                    end else if (st_q.cnt == '0) begin
                        st_d.state = ST_IDLE;
                        st_d.vld   = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                ST_CAL, ST_AZ, ST_PUP: begin
                    if (st_q.cnt == '0) st_d.state = ST_IDLE;
                    else                st_d.cnt   = st_q.cnt - ONE;
                end
                ST_PDN: begin
                    if (st_q.pd || (launch && op == OP_PUP)) begin
                        st_d.state = ST_PUP;
                        st_d.cnt   = CNT_W'(PUP_LEN - 1);
                    end
                end
                default: st_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.cnt   <= '0;
            st_q.acq   <= '0;
            st_q.rdy   <= 1'b0;
            st_q.pd    <= 1'b0;
            st_q.vld   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acq_held  = st_q.acq;
    assign busy_n    = (st_q.state == ST_IDLE);
    assign sample_en = (st_q.state == ST_ACQ);
    assign conv_act  = (st_q.state == ST_CONV);
    assign res_vld   = st_q.vld;

    AST_VLD_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> busy_n); // R1
    AST_VLD_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(conv_act)); // R4
    AST_SAMPLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_en) |-> (conv_act || $past(pd_s))); // R4
    AST_PIN_FORCES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pd_s |=> !busy_n); // R7
    AST_PIN_KILLS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        pd_s |=> (!conv_act && !res_vld)); // R7
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
    import seq_pkg::*;
#(
    parameter int ACQ0     = 6,
    parameter int ACQ1     = 10,
    parameter int ACQ2     = 18,
    parameter int ACQ3     = 34,
    parameter int CONV_LEN = 44,
    parameter int CAL_LEN  = 4944,
    parameter int AZ_LEN   = 76,
    parameter int PUP_LEN  = 3500,
    parameter int SYNC_STG = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_rdy,
    input  logic [2:0] cmd_op,
    input  logic [1:0] acq_code,
    input  logic       abort,
    input  logic       pd_pin,
    output logic       busy_n,
    output logic       sample_en,
    output logic       conv_act,
    output logic       res_vld
);
    localparam int MAX_LEN = max2(max2(max2(ACQ3, CONV_LEN), max2(CAL_LEN, AZ_LEN)),
                                  max2(PUP_LEN, max2(ACQ0, max2(ACQ1, ACQ2))));
    localparam int CNT_W   = $clog2(MAX_LEN) + 1;

    logic [1:0]       sync_q;
    logic [1:0]       acq_held;
    logic [CNT_W-1:0] launch_len;
    logic [CNT_W-1:0] restart_len;

    seq_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pd_pin, xfer_rdy}),
        .dout (sync_q)
    );

    seq_acq_len #(.CNT_W(CNT_W), .ACQ0(ACQ0), .ACQ1(ACQ1), .ACQ2(ACQ2), .ACQ3(ACQ3)) u_len_new (
        .code(acq_code),
        .len (launch_len)
    );

    seq_acq_len #(.CNT_W(CNT_W), .ACQ0(ACQ0), .ACQ1(ACQ1), .ACQ2(ACQ2), .ACQ3(ACQ3)) u_len_held (
        .code(acq_held),
        .len (restart_len)
    );

    seq_core #(
        .CNT_W   (CNT_W),
        .CONV_LEN(CONV_LEN),
        .CAL_LEN (CAL_LEN),
        .AZ_LEN  (AZ_LEN),
        .PUP_LEN (PUP_LEN)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .rdy_s      (sync_q[0]),
        .pd_s       (sync_q[1]),
        .op         (cmd_op),
        .acq_code   (acq_code),
        .abort      (abort),
        .launch_len (launch_len),
        .restart_len(restart_len),
        .acq_held   (acq_held),
        .busy_n     (busy_n),
        .sample_en  (sample_en),
        .conv_act   (conv_act),
        .res_vld    (res_vld)
    );
endmodule

// File: tb/sim_conv_seq_top.sv
`timescale 1ns/1ps
module sim_conv_seq_top;
    localparam real HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_rdy = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] acq_code = 2'd0;
    logic       abort = 1'b0;
    logic       pd_pin = 1'b0;
    logic       busy_n, sample_en, conv_act, res_vld;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #(HALF) clk = ~clk;

    conv_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .xfer_rdy(xfer_rdy), .cmd_op(cmd_op),
        .acq_code(acq_code), .abort(abort), .pd_pin(pd_pin),
        .busy_n(busy_n), .sample_en(sample_en), .conv_act(conv_act), .res_vld(res_vld)
    );

    function automatic int acq_len(input logic [1:0] c);
        case (c)
            2'd0: return 6;
            2'd1: return 10;
            2'd2: return 18;
            default: return 34;
        endcase
    endfunction

    function automatic int busy_len(input logic [2:0] op, input logic [1:0] c);
        case (op)
            3'd1: return acq_len(c) + 44;
            3'd2: return 4944;
            3'd3: return 76;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // raise the ready flag with a command; return edges until busy falls
    task automatic launch(input logic [2:0] op, input logic [1:0] c, output int n);
        @(negedge clk);
        cmd_op = op; acq_code = c; xfer_rdy = 1'b1;
        n = 0;
        do begin tick(); n++; end while (busy_n && n < 10);
    endtask

    task automatic drop_rdy();
        @(negedge clk);
        xfer_rdy = 1'b0;
        tick(); tick(); tick();
    endtask

    task automatic run_op(input logic [2:0] op, input logic [1:0] c, input string req);
        int n, lo, se, ca, vb;
        launch(op, c, n);
        chk(n == 3, "R2 launch latency", n, 3);
        lo = 0; se = 0; ca = 0; vb = 0;
        while (!busy_n && lo < 6000) begin
            se += int'(sample_en); ca += int'(conv_act); vb += int'(res_vld);
            tick(); lo++;
        end
        chk(lo == busy_len(op, c), req, lo, busy_len(op, c));
        chk(vb == 0, "R1 no strobe while busy", vb, 0);
        if (op == 3'd1) begin
            chk(se == acq_len(c), "R3 sample window", se, acq_len(c));
            chk(ca == 44, "R4 conversion window", ca, 44);
            chk(res_vld == 1'b1, "R4 result strobe", int'(res_vld), 1);
            tick();
            chk(res_vld == 1'b0, "R4 strobe one cycle", int'(res_vld), 0);
        end else begin
            chk(res_vld == 1'b0, "R1 no strobe for non-conversion", int'(res_vld), 0);
        end
        drop_rdy();
    endtask

    task automatic run_ignored(input logic [2:0] op, input string req);
        int n, lo;
        launch(op, 2'd0, n);
        lo = 0;
        for (int i = 0; i < 20; i++) begin
            if (!busy_n || sample_en || conv_act || res_vld) lo++;
            tick();
        end
        chk(n == 10 && lo == 0, req, lo, 0);
        drop_rdy();
    endtask

    initial begin
        #(HALF * 2 * 150000);
        checks++; errs++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        summary();
    end

    initial begin
        int n, lo, vb, m;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(busy_n == 1'b1, "R1 reset busy_n", int'(busy_n), 1);
        chk({sample_en, conv_act, res_vld} == 3'b000, "R1 reset outputs",
            int'({sample_en, conv_act, res_vld}), 0);

        // R3 R4 every sample setting
        for (int c = 0; c < 4; c++) run_op(3'd1, 2'(c), "R4 conversion busy time");
        run_op(3'd2, 2'd0, "R5 calibration busy time");
        run_op(3'd3, 2'd3, "R6 auto-zero busy time");

        // R11 ignored codes while idle
        run_ignored(3'd0, "R11 code 0 ignored");
        run_ignored(3'd6, "R11 code 6 ignored");
        run_ignored(3'd7, "R11 code 7 ignored");
        run_ignored(3'd5, "R11 power-up while idle ignored");

        // R11 launch while busy has no effect and queues nothing
        launch(3'd1, 2'd0, n);
        lo = 0;
        repeat (10) begin tick(); lo++; end
        @(negedge clk); xfer_rdy = 1'b0;
        repeat (3) begin tick(); lo++; end
        @(negedge clk); cmd_op = 3'd2; xfer_rdy = 1'b1;
        while (!busy_n && lo < 6000) begin tick(); lo++; end
        chk(lo == 50, "R11 launch while busy ignored", lo, 50);
        m = 0;
        for (int i = 0; i < 20; i++) begin if (!busy_n) m++; tick(); end
        chk(m == 0, "R11 nothing queued", m, 0);
        drop_rdy();

        // R10 abort during conversion window
        launch(3'd1, 2'd1, n);
        m = acq_len(2'd1) + 10;
        lo = 0; vb = 0;
        repeat (m) begin vb += int'(res_vld); tick(); lo++; end
        @(negedge clk); abort = 1'b1;
        tick(); lo++;
        @(negedge clk); abort = 1'b0;
        while (!busy_n && lo < 6000) begin vb += int'(res_vld); tick(); lo++; end
        chk(lo == m + 1 + acq_len(2'd1) + 44, "R10 abort restart length", lo, m + 1 + acq_len(2'd1) + 44);
        chk(vb == 0, "R10 no strobe for aborted conversion", vb, 0);
        drop_rdy();

        // R7 pin during conversion, R8 release timing
        launch(3'd1, 2'd3, n);
        repeat (40) tick();
        @(negedge clk); pd_pin = 1'b1;
        tick(); tick(); tick();
        chk(conv_act == 1'b0, "R7 conversion terminated", int'(conv_act), 0);
        vb = 0; lo = 0;
        for (int i = 0; i < 200; i++) begin
            vb += int'(res_vld); if (busy_n) lo++; tick();
        end
        chk(vb == 0 && lo == 0, "R7 held low without strobe", vb + lo, 0);
        @(negedge clk); xfer_rdy = 1'b0; pd_pin = 1'b0;
        n = 0;
        do begin tick(); n++; end while (!busy_n && n < 5000);
        chk(n == 3503, "R8 pin power-up time", n, 3503);

        // R9 software power down / up, R11 other code while down
        launch(3'd4, 2'd0, n);
        chk(n == 3, "R9 power-down launch", n, 3);
        lo = 0;
        for (int i = 0; i < 100; i++) begin if (busy_n) lo++; tick(); end
        chk(lo == 0, "R9 stays powered down", lo, 0);
        drop_rdy();
        launch(3'd1, 2'd0, n);
        lo = 0;
        for (int i = 0; i < 50; i++) begin if (busy_n || sample_en) lo++; tick(); end
        chk(lo == 0, "R11 convert while down ignored", lo, 0);
        drop_rdy();
        @(negedge clk); cmd_op = 3'd5; xfer_rdy = 1'b1;
        n = 0;
        do begin tick(); n++; end while (!busy_n && n < 5000);
        chk(n == 3503, "R9 software power-up time", n, 3503);
        drop_rdy();

        // random mix of R4 R5 R6
        for (int i = 0; i < 12; i++) begin
            logic [2:0] op;
            logic [1:0] c;
            op = 3'($urandom_range(1, 3));
            c  = 2'($urandom_range(0, 3));
            run_op(op, c, (op == 3'd1) ? "R4 random conversion" :
                          (op == 3'd2) ? "R5 random calibration" : "R6 random auto-zero");
        end

        summary();
    end
endmodule